// File: doc/BRIEF.md
# Byte Arithmetic Unit with Decimal and Overflow Flags

This block does the byte arithmetic of a small 8-bit controller. It works on an accumulator operand A and a second operand B, together with the incoming carry (C), auxiliary carry (AC) and overflow (OV) flags. It returns new A and B bytes and new flag values. The operations are add, add with carry, subtract with borrow, increment, decrement, unsigned multiply, unsigned divide and decimal adjust. The block holds no register file and decodes no instructions. The surrounding core presents the operands and flags with a one-cycle `start` pulse, waits for `done` and then writes the results back.

Most operations finish in one cycle. Multiply and divide run through an iterative shift datapath and take several cycles. The controller is a four-state machine. `S_IDLE` waits for `start`. From there it takes transition *go_mul* to `S_MUL` or *go_div* to `S_DIV`, or it takes *go_quick* straight to `S_DONE`. *go_quick* is used for the single-cycle operations and for a divide by a zero divisor. `S_MUL` and `S_DIV` each take *finish* to `S_DONE` once the last step has been performed and the result captured. `S_DONE` always takes *retire* back to `S_IDLE`. Results stay on the outputs until the next operation is accepted.

The operation code `op` uses these values: 0 add, 1 add with carry, 2 subtract with borrow, 3 increment, 4 decrement, 5 multiply, 6 divide, 7 decimal adjust.

Top module: `byte_alu`

## Requirements
- R1: After reset, `a_out`, `b_out`, `c_out`, `ac_out`, `ov_out`, `done` and `busy` are all 0.
- R2: Add (op 0) ignores `c_in` and add with carry (op 1) includes it. `a_out` is the low byte of A + B (+ C). C is set when the sum exceeds FFh, AC is set on a carry out of bit 3, and OV is the XOR of the carries out of bits 7 and 6. For example, 3Fh + D3h gives 12h with C=1, AC=1, OV=0.
- R3: Subtract (op 2) always computes A − B − `c_in`. C is set on a borrow out of bit 7, AC on a borrow out of bit 3, and OV when the signed result leaves the range −128..127.
- R4: Increment (op 3) and decrement (op 4) act on A and wrap modulo 256. C, AC and OV keep their incoming values.
- R5: Multiply (op 5) puts the high byte of the unsigned 16-bit product in `b_out` and the low byte in `a_out`. It clears C, sets OV exactly when the product exceeds FFh, and keeps AC. For example, FFh × FFh gives B=FEh, A=01h.
- R6: Divide (op 6) with a non-zero B puts the quotient in `a_out` and the remainder in `b_out`. It clears C and OV and keeps AC.
- R7: Divide (op 6) with B = 0 sets OV, clears C, keeps AC, and returns A and B unchanged.
- R8: Decimal adjust (op 7) adds 06h when the low nibble of A exceeds 9 or AC is set. It then adds 60h when the high nibble exceeds 9 or C is set (or the first step carried out of bit 7). C is set if either of those conditions held or the second addition carries out of bit 7. For example, 4Ch becomes 52h and 9Ah becomes 00h with C=1. AC and OV are kept.
- R9: For every operation other than multiply and divide, `b_out` equals `b_in`.
- R10: `done` is high for exactly one cycle. Count the rising edge that accepts `start` as edge 1. For single-cycle operations and a zero-divisor divide, `done` is high after edge 1. For multiply and divide with a non-zero divisor, it is high after edge WIDTH+2 (10 with the default width).
- R11: `start` is only accepted while `busy` is 0. A `start` raised while an operation is in progress has no effect on that operation's result or timing.
- R12: Outputs hold their values between operations and change only when an operation completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation with the operands now present |
| op | input | 3 | Operation code (see R2 to R8) |
| a_in | input | 8 | Accumulator operand |
| b_in | input | 8 | Second operand |
| c_in | input | 1 | Incoming carry flag |
| ac_in | input | 1 | Incoming auxiliary carry flag |
| ov_in | input | 1 | Incoming overflow flag |
| busy | output | 1 | An accepted operation has not yet retired |
| done | output | 1 | One-cycle pulse: results are valid |
| a_out | output | 8 | Result for the accumulator |
| b_out | output | 8 | Result for B |
| c_out | output | 1 | Result carry flag |
| ac_out | output | 1 | Result auxiliary carry flag |
| ov_out | output | 1 | Result overflow flag |

## Verification
The hardest case to reach from the ports is a second `start` that arrives while a multiply is stepping through `S_MUL`. The controller must ignore it, and the operands of that ignored request must not leak into the datapath. The bench launches a multiply and then holds `start` high with a different operation and different operands for several of the iteration cycles. It then checks both the product and the exact cycle in which `done` appears. Decimal adjust with a carry out of the low-nibble correction and a divide by zero are also driven explicitly, because ordinary operands never produce them.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDC = 3'd1,
        OP_SUBB = 3'd2,
        OP_INC  = 3'd3,
        OP_DEC  = 3'd4,
        OP_MUL  = 3'd5,
        OP_DIV  = 3'd6,
        OP_DA   = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_MUL  = 2'd1,
        S_DIV  = 2'd2,
        S_DONE = 2'd3
    } alu_state_e;

endpackage

// File: rtl/alu_addsub.sv
// Ripple adder/subtractor that exposes the intermediate carries for flags.
module alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         c_flag,
    output logic         ac_flag,
    output logic         ov_flag
);
    localparam int HALF = W / 2;

    logic [W:0]   cy;
    logic [W-1:0] bx;

    assign bx    = opb ^ {W{sub}};
    // In subtract mode the incoming borrow enters as an inverted carry.
    assign cy[0] = sub ? ~cin : cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign res[i]  = opa[i] ^ bx[i] ^ cy[i];
        assign cy[i+1] = (opa[i] & bx[i]) | (opa[i] & cy[i]) | (bx[i] & cy[i]);
    end

    // A borrow is the inverse of the carry when subtracting.
    assign c_flag  = cy[W] ^ sub;
    assign ac_flag = cy[HALF] ^ sub;
    assign ov_flag = cy[W] ^ cy[W-1];

endmodule

// File: rtl/alu_decadj.sv
// Two-step decimal correction of a packed BCD byte.
module alu_decadj #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    input  logic         c_in,
    input  logic         ac_in,
    output logic [W-1:0] res,
    output logic         c_out
);
    localparam int HALF = W / 2;
    localparam logic [W:0] LOW_FIX  = (W+1)'(6);
    localparam logic [W:0] HIGH_FIX = (W+1)'(6) << HALF;

    logic [W:0] step1;
    logic [W:0] step2;
    logic       low_bad;
    logic       high_bad;
    logic       c_mid;

    always_comb begin
        low_bad  = ac_in || (val[HALF-1:0] > HALF'(9));
        step1    = {1'b0, val} + (low_bad ? LOW_FIX : '0);
        c_mid    = c_in | step1[W];
        high_bad = c_mid || (step1[W-1:HALF] > (W-HALF)'(9));
        step2    = {1'b0, step1[W-1:0]} + (high_bad ? HIGH_FIX : '0);
        res      = step2[W-1:0];
        c_out    = high_bad | step2[W];
    end

endmodule

// File: rtl/alu_muldiv.sv
// Iterative one-bit-per-cycle unsigned multiplier and restoring divider.
module alu_muldiv #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         is_div,
    input  logic         step,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] res_hi,
    output logic [W-1:0] res_lo
);
    logic           mode_div_q;
    logic [W-1:0]   dvs_q;
    logic [2*W:0]   prod_q;
    logic [W-1:0]   rem_q;
    logic [W-1:0]   quo_q;

    logic [W:0]     psum;
    logic [2*W:0]   prod_next;
    logic [W:0]     shifted;
    logic [W:0]     trial;

    always_comb begin
        psum      = {1'b0, prod_q[2*W-1:W]} + (prod_q[0] ? {1'b0, dvs_q} : '0);
        prod_next = {psum, prod_q[W-1:0]} >> 1;
        shifted   = {rem_q, quo_q[W-1]};
        trial     = shifted - {1'b0, dvs_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_div_q <= 1'b0;
            dvs_q      <= '0;
            prod_q     <= '0;
            rem_q      <= '0;
            quo_q      <= '0;
        end else if (load) begin
            mode_div_q <= is_div;
            if (is_div) begin
                dvs_q <= opb;
                rem_q <= '0;
                quo_q <= opa;
            end else begin
                dvs_q  <= opa;
                prod_q <= {(W+1)'(0), opb};
            end
        end else if (step) begin
            if (mode_div_q) begin
                if (!trial[W]) begin
                    rem_q <= trial[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
            end else begin
                prod_q <= prod_next;
            end
        end
    end

    assign res_hi = mode_div_q ? rem_q : prod_q[2*W-1:W];
    assign res_lo = mode_div_q ? quo_q : prod_q[W-1:0];

endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [2:0]   op,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         c_in,
    input  logic         ac_in,
    input  logic         ov_in,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output logic         c_out,
    output logic         ac_out,
    output logic         ov_out
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W);

    alu_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q;
    alu_op_e      op_in, op_q;
    logic         c_q, ac_q;
    logic         accept, div_zero, iter_end;

    logic [W-1:0] as_b;
    logic         as_cin, as_sub;
    logic [W-1:0] as_res;
    logic         as_c, as_ac, as_ov;
    logic [W-1:0] da_res;
    logic         da_c;
    logic [W-1:0] md_hi, md_lo;
    logic         md_load, md_step;

    assign op_in    = alu_op_e'(op);
    assign accept   = start && (state_q == S_IDLE);
    assign div_zero = (b_in == '0);
    assign iter_end = ((state_q == S_MUL) || (state_q == S_DIV)) && (cnt_q == LAST);

    // Operand steering for the shared adder.
    always_comb begin
        as_b   = b_in;
        as_cin = 1'b0;
        as_sub = 1'b0;
        unique case (op_in)
            OP_ADDC: as_cin = c_in;
            OP_SUBB: begin as_sub = 1'b1; as_cin = c_in; end
            OP_INC:  as_b = W'(1);
            OP_DEC:  begin as_b = W'(1); as_sub = 1'b1; end
            default: ;
        endcase
    end

    alu_addsub #(.W(W)) i_addsub (
        .opa(a_in), .opb(as_b), .cin(as_cin), .sub(as_sub),
        .res(as_res), .c_flag(as_c), .ac_flag(as_ac), .ov_flag(as_ov)
    );

    alu_decadj #(.W(W)) i_decadj (
        .val(a_in), .c_in(c_in), .ac_in(ac_in), .res(da_res), .c_out(da_c)
    );

    assign md_load = accept && ((op_in == OP_MUL) || ((op_in == OP_DIV) && !div_zero));
    assign md_step = ((state_q == S_MUL) || (state_q == S_DIV)) && (cnt_q != LAST);

    alu_muldiv #(.W(W)) i_muldiv (
        .clk(clk), .rst_n(rst_n), .load(md_load), .is_div(op_in == OP_DIV),
        .step(md_step), .opa(a_in), .opb(b_in), .res_hi(md_hi), .res_lo(md_lo)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    if (op_in == OP_MUL)                  state_d = S_MUL;   // go_mul
                    else if (op_in == OP_DIV && !div_zero) state_d = S_DIV;  // go_div
                    else                                   state_d = S_DONE; // go_quick
                end
            end
            S_MUL, S_DIV: if (cnt_q == LAST) state_d = S_DONE;               // finish
            S_DONE: state_d = S_IDLE;                                        // retire
            default: state_d = S_IDLE;
        endcase
    end

    // State register and iteration counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept)       cnt_q <= '0;
            else if (md_step) cnt_q <= cnt_q + CW'(1);
        end
    end

    // Result registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_ADD;
            c_q    <= 1'b0;
            ac_q   <= 1'b0;
            a_out  <= '0;
            b_out  <= '0;
            c_out  <= 1'b0;
            ac_out <= 1'b0;
            ov_out <= 1'b0;
        end else if (accept) begin
            op_q <= op_in;
            c_q  <= c_in;
            ac_q <= ac_in;
            unique case (op_in)
                OP_ADD, OP_ADDC, OP_SUBB: begin
                    a_out  <= as_res;
                    b_out  <= b_in;
                    c_out  <= as_c;
                    ac_out <= as_ac;
                    ov_out <= as_ov;
                end
                OP_INC, OP_DEC: begin
                    a_out  <= as_res;
                    b_out  <= b_in;
                    c_out  <= c_in;
                    ac_out <= ac_in;
                    ov_out <= ov_in;
                end
                OP_DA: begin
                    a_out  <= da_res;
                    b_out  <= b_in;
                    c_out  <= da_c;
                    ac_out <= ac_in;
                    ov_out <= ov_in;
                end
                OP_DIV: begin
                    if (div_zero) begin
                        a_out  <= a_in;
                        b_out  <= b_in;
                        c_out  <= 1'b0;
                        ac_out <= ac_in;
                        ov_out <= 1'b1;
                    end
                end
                OP_MUL: ;
                default: ;
            endcase
        end else if (iter_end) begin
            a_out  <= md_lo;
            b_out  <= md_hi;
            c_out  <= 1'b0;
            ac_out <= ac_q;
            ov_out <= (state_q == S_MUL) ? (md_hi != '0) : 1'b0;
        end
    end

    assign done = (state_q == S_DONE);
    assign busy = (state_q != S_IDLE);

endmodule

// File: rtl/alu_chk.sv
module alu_chk
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input alu_state_e   state_q,
    input alu_op_e      op_q,
    input logic         c_q,
    input logic         c_out,
    input logic         ov_out,
    input logic [W-1:0] a_out,
    input logic [W-1:0] b_out
);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_q != S_DONE) |=> (state_q == S_MUL || state_q == S_DIV || state_q == S_DONE));

    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_IDLE && !start) || state_q == S_DONE)
        |=> ($stable(a_out) && $stable(b_out) && $stable(c_out) && $stable(ov_out)));

    a_r5_mul_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_MUL) |-> (!c_out && (ov_out == (b_out != '0))));

    a_r6_div_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_DIV) |-> !c_out);

    a_r4_keep_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op_q == OP_INC || op_q == OP_DEC)) |-> (c_out == c_q));

endmodule

bind byte_alu alu_chk #(.W(W)) i_chk (.*);

// File: tb/test_byte_alu.sv
module test_byte_alu;
    localparam int CLK_P = 10;
    localparam int WB    = 8;
    localparam int LONG_LAT = WB + 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] op = 3'd0;
    logic [7:0] a_in = 8'h00, b_in = 8'h00;
    logic       c_in = 1'b0, ac_in = 1'b0, ov_in = 1'b0;
    logic       busy, done, c_out, ac_out, ov_out;
    logic [7:0] a_out, b_out;

    int nvec = 0;
    int nbad = 0;

    always #(CLK_P/2) clk = ~clk;

    byte_alu i_byte_alu (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .a_in(a_in), .b_in(b_in), .c_in(c_in), .ac_in(ac_in), .ov_in(ov_in),
        .busy(busy), .done(done), .a_out(a_out), .b_out(b_out),
        .c_out(c_out), .ac_out(ac_out), .ov_out(ov_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input int ea, input int eb,
                           input int ec, input int eac, input int eov);
        chk({tag, " A"}, a_out, ea);
        chk({tag, " B"}, b_out, eb);
        chk({tag, " C"}, c_out, ec);
        chk({tag, " AC"}, ac_out, eac);
        chk({tag, " OV"}, ov_out, eov);
    endtask

    // Launch one operation and return the edge count until done is seen.
    task automatic run_op(input int o, input int a, input int b,
                          input bit c, input bit ac, input bit ov, output int lat);
        @(negedge clk);
        while (busy) @(negedge clk);
        op = 3'(o); a_in = 8'(a); b_in = 8'(b);
        c_in = c; ac_in = ac; ov_in = ov; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 50) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
    endtask

    function automatic int sgn(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    task automatic t_reset();
        chk("R1 a", a_out, 0); chk("R1 b", b_out, 0);
        chk("R1 flags", {c_out, ac_out, ov_out}, 0);
        chk("R1 done", done, 0); chk("R1 busy", busy, 0);
    endtask

    task automatic t_add(input int o, input int a, input int b, input bit c);
        int lat, cin, s, ss;
        cin = (o == 1) ? int'(c) : 0;
        run_op(o, a, b, c, 1'b0, 1'b0, lat);
        s  = a + b + cin;
        ss = sgn(a) + sgn(b) + cin;
        chk_all("R2 add", s & 255, b, int'(s > 255),
                int'(((a & 15) + (b & 15) + cin) > 15), int'(ss > 127 || ss < -128));
        chk("R10 add latency", lat, 1);
    endtask

    task automatic t_sub(input int a, input int b, input bit c);
        int lat, d, ss;
        run_op(2, a, b, c, 1'b0, 1'b0, lat);
        d  = a - b - int'(c);
        ss = sgn(a) - sgn(b) - int'(c);
        chk_all("R3 subb", d & 255, b, int'(d < 0),
                int'(((a & 15) - (b & 15) - int'(c)) < 0), int'(ss > 127 || ss < -128));
    endtask

    task automatic t_incdec(input bit is_dec, input int a, input bit c, input bit ac, input bit ov);
        int lat;
        run_op(is_dec ? 4 : 3, a, 8'h5A, c, ac, ov, lat);
        chk_all("R4 incdec", is_dec ? ((a + 255) & 255) : ((a + 1) & 255), 8'h5A, c, ac, ov);
        chk("R9 incdec b passthrough", b_out, 8'h5A);
    endtask

    task automatic t_mul(input int a, input int b, input bit ac);
        int lat, p;
        run_op(5, a, b, 1'b1, ac, 1'b0, lat);
        p = a * b;
        chk_all("R5 mul", p & 255, p >> 8, 0, ac, int'(p > 255));
        chk("R10 mul latency", lat, LONG_LAT);
    endtask

    task automatic t_div(input int a, input int b, input bit ac);
        int lat;
        run_op(6, a, b, 1'b1, ac, 1'b1, lat);
        if (b == 0) begin
            chk_all("R7 div zero", a, b, 0, ac, 1);
            chk("R10 divzero latency", lat, 1);
        end else begin
            chk_all("R6 div", a / b, a % b, 0, ac, 0);
            chk("R10 div latency", lat, LONG_LAT);
        end
    endtask

    task automatic t_da(input int a, input bit c, input bit ac, input int ea, input bit ec);
        int lat;
        run_op(7, a, 8'h33, c, ac, 1'b1, lat);
        chk_all("R8 decadj", ea, 8'h33, ec, ac, 1);
    endtask

    task automatic t_busy_ignore();
        int lat;
        @(negedge clk);
        while (busy) @(negedge clk);
        op = 3'd5; a_in = 8'h0C; b_in = 8'h05; c_in = 1'b0; ac_in = 1'b0; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // Disturb: a different request while stepping.
        op = 3'd0; a_in = 8'hAA; b_in = 8'h77;
        lat = 1;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        while (!done && lat < 50) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        chk_all("R11 ignored start", 8'h3C, 8'h00, 0, 0, 0);
        chk("R11 latency", lat, LONG_LAT);
    endtask

    task automatic t_hold();
        int lat;
        run_op(0, 8'h21, 8'h12, 1'b0, 1'b0, 1'b0, lat);
        @(negedge clk);
        a_in = 8'hFF; b_in = 8'hFF; op = 3'd5; c_in = 1'b1;
        for (int k = 0; k < 5; k++) @(negedge clk);
        chk_all("R12 hold", 8'h33, 8'h12, 0, 0, 0);
        chk("R12 done low", done, 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        nbad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_add(0, 8'h3F, 8'hD3, 1'b1);
        chk("R2 example A", a_out, 8'h12);
        chk("R2 example flags", {c_out, ac_out, ov_out}, 3'b110);
        t_add(0, 8'h01, 8'h01, 1'b1);
        t_add(1, 8'h7F, 8'h00, 1'b1);
        t_add(1, 8'hFF, 8'hFF, 1'b1);
        t_sub(8'h50, 8'h4F, 1'b1);
        t_sub(8'h00, 8'h01, 1'b0);
        t_sub(8'h80, 8'h01, 1'b0);
        t_sub(8'h7F, 8'hFF, 1'b1);
        t_incdec(1'b0, 8'hFF, 1'b0, 1'b1, 1'b0);
        t_incdec(1'b0, 8'h3E, 1'b1, 1'b0, 1'b1);
        t_incdec(1'b1, 8'h00, 1'b1, 1'b1, 1'b1);
        t_incdec(1'b1, 8'h80, 1'b0, 1'b0, 1'b0);
        t_mul(8'hFF, 8'hFF, 1'b1);
        t_mul(8'h0C, 8'h05, 1'b0);
        t_mul(8'h00, 8'h9D, 1'b0);
        t_div(8'hFB, 8'h12, 1'b1);
        t_div(8'h07, 8'h09, 1'b0);
        t_div(8'hFF, 8'h01, 1'b0);
        t_div(8'h55, 8'h00, 1'b1);
        t_da(8'h4C, 1'b0, 1'b0, 8'h52, 1'b0);
        t_da(8'h9A, 1'b0, 1'b0, 8'h00, 1'b1);
        t_da(8'h41, 1'b0, 1'b1, 8'h47, 1'b0);
        t_da(8'h12, 1'b1, 1'b0, 8'h72, 1'b1);
        t_da(8'hFA, 1'b0, 1'b0, 8'h60, 1'b1);
        t_busy_ignore();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule